// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This block keeps wall-clock time and a calendar date. It is driven by a one-cycle enable pulse at the slow oscillator rate, 32768 pulses per second by default. A prescaler turns those pulses into one-second steps. A chain of counters then carries seconds into minutes, hours, day, month and year. The day rollover follows the length of the current month, and February has 28 or 29 days depending on a leap flag that software keeps.

Software reaches the block through a small 32-bit register bus with three word registers:

| Byte offset | Register |
|---|---|
| 0x00 | Control |
| 0x04 | Date |
| 0x08 | Time |

- **Control** chooses between the internal and external oscillator and holds two further settings. A write changes it only when it carries a 16-bit key.
- **Date and time** can be read at any moment and return the live counters.
- **Busy flags.** Each accepted write raises a busy flag in the control register for a fixed number of slow ticks. This stands in for the transfer of the value into the slow domain. Software polls the flag before it writes again.

Top module: `rtc_core`

## Requirements
- R1: A synchronous active-high reset sets the calendar to year offset 0, month 1, day 1, time 00:00:00, leap flag 0. It also clears the control bits, the busy flags and the prescaler. After reset the date register reads 0x00000101 and the time and control registers read 0.
- R2: The seconds count advances by one on the slow tick that completes TICKS_PER_SEC slow ticks since reset or since the last time-register write. A time write restarts this count.
- R3: Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0 and carry into the day.
- R4: When the day passes the month length it returns to 1 and the month advances. Month lengths are:
  - 30 days for months 4, 6, 9 and 11.
  - 28 days for month 2 with the leap flag clear.
  - 29 days for month 2 with the leap flag set.
  - 31 days for every other month.
- R5: When month 12 rolls over, the month returns to 1 and the 6-bit year offset (year minus 2010) increments. The leap flag is never changed by counting.
- R6: A write to the time register never changes the date fields, even when it coincides with a second step. A date write replaces day, month, year and leap flag together.
- R7: A write to the control register (offset 0x00) updates it only if bits [31:16] equal 0x16AA. Otherwise the register is unchanged and no busy flag rises.
  - Bit 0 selects the external oscillator and also drives `ext_osc_sel`.
  - Bit 3 is a drive setting.
  - Bit 14 enables automatic switching.
- R8: Control bits [9:7] are read-only busy flags: bit 7 for control, bit 8 for date, bit 9 for time. An accepted write sets its flag at the next clock edge. The flag then stays set until BUSY_TICKS (default 3) slow ticks have passed.
- R9: The time register places seconds at [5:0], minutes at [13:8] and hours at [20:16]. The date register places day at [4:0], month at [11:8], year offset at [21:16] and the leap flag at bit 22. All other bits, and any unmapped offset, read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_tick | input | 1 | One-cycle enable at the slow oscillator rate |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ext_osc_sel | output | 1 | High when the external oscillator is selected |

## Verification
The hardest situations to reach from the ports are the calendar carries, such as a month end in a leap February or a year change. Waiting for them in real time would take days of simulated seconds. The bench instead writes a date just before the boundary, then writes 23:59:59, which also clears the prescaler. It then gives exactly TICKS_PER_SEC slow ticks, set small in the bench, so that a single second step triggers the full chain of carries. The busy windows are measured by counting slow ticks between the write and the poll.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_DATE = 8'h04;
    localparam logic [7:0] OFF_TIME = 8'h08;

    localparam logic [15:0] CTRL_KEY = 16'h16AA;

    localparam int NUM_BUSY  = 3;
    localparam int BUSY_CTRL = 0;
    localparam int BUSY_DATE = 1;
    localparam int BUSY_TIME = 2;

    typedef struct packed {
        logic [5:0] sec;
        logic [5:0] min;
        logic [4:0] hour;
    } tod_t;

    typedef struct packed {
        logic [4:0] day;
        logic [3:0] mon;
        logic [5:0] year;
        logic       leap;
    } ymd_t;

    function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic leap);
        logic [4:0] len;
        case (mon)
            4'd2:                      len = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   len = 5'd30;
            default:                   len = 5'd31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_tick,
    input  logic restart,
    output logic sec_step
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    assign sec_step = slow_tick && !restart && (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (slow_tick) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= LAST);

    // R2
    pre_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> st_q.cnt == '0);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sec_step,
    input  logic load_tod,
    input  tod_t tod_in,
    input  logic load_ymd,
    input  ymd_t ymd_in,
    output tod_t tod,
    output ymd_t ymd
);
    typedef struct packed {
        tod_t t;
        ymd_t d;
    } cal_t;

    localparam cal_t CAL_RESET = '{
        t: '{sec: 6'd0, min: 6'd0, hour: 5'd0},
        d: '{day: 5'd1, mon: 4'd1, year: 6'd0, leap: 1'b0}
    };

    cal_t st_d, st_q;
    cal_t rolled;
    logic carry_min, carry_hour, carry_day, carry_mon, carry_year;

    always_comb begin
        rolled     = st_q;
        carry_min  = 1'b0;
        carry_hour = 1'b0;
        carry_day  = 1'b0;
        carry_mon  = 1'b0;
        carry_year = 1'b0;
        if (sec_step) begin
            if (st_q.t.sec >= 6'd59) begin
                rolled.t.sec = '0;
                carry_min    = 1'b1;
            end else begin
                rolled.t.sec = st_q.t.sec + 6'd1;
            end
        end
        if (carry_min) begin
            if (st_q.t.min >= 6'd59) begin
                rolled.t.min = '0;
                carry_hour   = 1'b1;
            end else begin
                rolled.t.min = st_q.t.min + 6'd1;
            end
        end
        if (carry_hour) begin
            if (st_q.t.hour >= 5'd23) begin
                rolled.t.hour = '0;
                carry_day     = 1'b1;
            end else begin
                rolled.t.hour = st_q.t.hour + 5'd1;
            end
        end
        if (carry_day) begin
            if (st_q.d.day >= days_in_month(st_q.d.mon, st_q.d.leap)) begin
                rolled.d.day = 5'd1;
                carry_mon    = 1'b1;
            end else begin
                rolled.d.day = st_q.d.day + 5'd1;
            end
        end
        if (carry_mon) begin
            if (st_q.d.mon >= 4'd12) begin
                rolled.d.mon = 4'd1;
                carry_year   = 1'b1;
            end else begin
                rolled.d.mon = st_q.d.mon + 4'd1;
            end
        end
        if (carry_year) begin
            rolled.d.year = st_q.d.year + 6'd1;
        end
    end

    always_comb begin
        st_d = rolled;
        if (load_tod) begin
            st_d.t = tod_in;
            st_d.d = st_q.d;
        end
        if (load_ymd) begin
            st_d.d = ymd_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= CAL_RESET;
        else     st_q <= st_d;
    end

    assign tod = st_q.t;
    assign ymd = st_q.d;

    // R6
    tod_keeps_date_chk: assert property (@(posedge clk) disable iff (rst)
        (load_tod && !load_ymd) |=> $stable(ymd));

    // R5
    leap_held_chk: assert property (@(posedge clk) disable iff (rst)
        !load_ymd |=> ymd.leap == $past(ymd.leap));

    // R3
    sec_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (!sec_step && !load_tod) |=> $stable(tod));

    // R4
    day_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_step && !load_ymd && !load_tod && ymd.day != 5'd0) |=> ymd.day != 5'd0);

endmodule

// File: rtl/rtc_busy.sv
module rtc_busy #(
    parameter int NUM        = 3,
    parameter int BUSY_TICKS = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           slow_tick,
    input  logic [NUM-1:0] start,
    output logic [NUM-1:0] busy
);
    localparam int BW = $clog2(BUSY_TICKS + 1);
    localparam logic [BW-1:0] LOAD = BW'(BUSY_TICKS);

    typedef struct packed {
        logic [NUM-1:0][BW-1:0] cnt;
    } busy_t;

    busy_t st_d, st_q;
    logic [NUM-1:0][BW-1:0] cnt_nxt;

    for (genvar g = 0; g < NUM; g++) begin : g_flag
        always_comb begin
            if (start[g])
                cnt_nxt[g] = LOAD;
            else if (slow_tick && st_q.cnt[g] != '0)
                cnt_nxt[g] = st_q.cnt[g] - 1'b1;
            else
                cnt_nxt[g] = st_q.cnt[g];
        end
        assign busy[g] = (st_q.cnt[g] != '0);

        // R8
        busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
            start[g] |=> busy[g]);

        // R8
        busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (busy[g] && !slow_tick) |=> busy[g]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int BUSY_TICKS    = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_tick,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        ext_osc_sel
);
    typedef struct packed {
        logic osc_ext;
        logic drive;
        logic auto_sw;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic wr_any, wr_ctrl, wr_date, wr_time, key_ok;
    logic sec_step;
    logic [NUM_BUSY-1:0] busy_start, busy;
    tod_t tod, tod_in;
    ymd_t ymd, ymd_in;

    assign wr_any  = bus_sel && bus_wr;
    assign key_ok  = (bus_wdata[31:16] == CTRL_KEY);
    assign wr_ctrl = wr_any && (bus_addr == OFF_CTRL) && key_ok;
    assign wr_date = wr_any && (bus_addr == OFF_DATE);
    assign wr_time = wr_any && (bus_addr == OFF_TIME);

    assign tod_in = '{sec: bus_wdata[5:0], min: bus_wdata[13:8], hour: bus_wdata[20:16]};
    assign ymd_in = '{day: bus_wdata[4:0], mon: bus_wdata[11:8],
                      year: bus_wdata[21:16], leap: bus_wdata[22]};

    always_comb begin
        busy_start            = '0;
        busy_start[BUSY_CTRL] = wr_ctrl;
        busy_start[BUSY_DATE] = wr_date;
        busy_start[BUSY_TIME] = wr_time;
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.osc_ext = bus_wdata[0];
            st_d.drive   = bus_wdata[3];
            st_d.auto_sw = bus_wdata[14];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .restart   (wr_time),
        .sec_step  (sec_step)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst      (rst),
        .sec_step (sec_step),
        .load_tod (wr_time),
        .tod_in   (tod_in),
        .load_ymd (wr_date),
        .ymd_in   (ymd_in),
        .tod      (tod),
        .ymd      (ymd)
    );

    rtc_busy #(.NUM(NUM_BUSY), .BUSY_TICKS(BUSY_TICKS)) u_busy (
        .clk       (clk),
        .rst       (rst),
        .slow_tick (slow_tick),
        .start     (busy_start),
        .busy      (busy)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_CTRL: begin
                bus_rdata[0]   = st_q.osc_ext;
                bus_rdata[3]   = st_q.drive;
                bus_rdata[14]  = st_q.auto_sw;
                bus_rdata[9:7] = busy;
            end
            OFF_DATE: begin
                bus_rdata[4:0]   = ymd.day;
                bus_rdata[11:8]  = ymd.mon;
                bus_rdata[21:16] = ymd.year;
                bus_rdata[22]    = ymd.leap;
            end
            OFF_TIME: begin
                bus_rdata[5:0]   = tod.sec;
                bus_rdata[13:8]  = tod.min;
                bus_rdata[20:16] = tod.hour;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign ext_osc_sel = st_q.osc_ext;

    // R7
    unkeyed_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_any && bus_addr == OFF_CTRL && !key_ok) |=> $stable(st_q));

    // R7
    keyed_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> ext_osc_sel == $past(bus_wdata[0]));

endmodule

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 4;
    localparam int BUSY_T     = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_osc_sel;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_core #(.TICKS_PER_SEC(TPS), .BUSY_TICKS(BUSY_T)) u_rtc_core (
        .clk         (clk),
        .rst         (rst),
        .slow_tick   (slow_tick),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ext_osc_sel (ext_osc_sel)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1'b1;
            @(negedge clk); slow_tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(8'h04, v); check(v, 32'h0000_0101, "R1 date after reset");
        rd(8'h08, v); check(v, 32'h0, "R1 time after reset");
        rd(8'h00, v); check(v, 32'h0, "R1 control after reset");
        check({31'b0, ext_osc_sel}, 32'h0, "R1 osc select after reset");
    endtask

    task automatic t_seconds();
        logic [31:0] v;
        wr(8'h08, 32'h0000_0005);
        ticks(TPS - 1);
        rd(8'h08, v); check(v, 32'h0000_0005, "R2 no step before full count");
        ticks(1);
        rd(8'h08, v); check(v, 32'h0000_0006, "R2 step on last tick");
        ticks(TPS - 2);
        wr(8'h08, 32'h0000_0010);
        ticks(TPS - 1);
        rd(8'h08, v); check(v, 32'h0000_0010, "R2 time write restarts prescaler");
    endtask

    task automatic t_hours();
        logic [31:0] v;
        wr(8'h04, 32'h0000_0305);
        wr(8'h08, 32'h000A_3B3B);
        ticks(TPS);
        rd(8'h08, v); check(v, 32'h000B_0000, "R3 minute and hour carry");
        rd(8'h04, v); check(v, 32'h0000_0305, "R3 date unchanged mid day");
    endtask

    task automatic roll(input logic [31:0] din, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        wr(8'h04, din);
        wr(8'h08, 32'h0017_3B3B);
        ticks(TPS);
        rd(8'h04, v); check(v, exp, tag);
        rd(8'h08, v); check(v, 32'h0, {tag, " time wraps"});
    endtask

    task automatic t_months();
        roll(32'h0000_010F, 32'h0000_0110, "R4 mid month day step");
        roll(32'h0000_041E, 32'h0000_0501, "R4 april ends at 30");
        roll(32'h0000_011F, 32'h0000_0201, "R4 january ends at 31");
        roll(32'h0000_021C, 32'h0000_0301, "R4 february 28 no leap");
        roll(32'h0040_021C, 32'h0040_021D, "R4 february 28 leap");
        roll(32'h0040_021D, 32'h0040_0301, "R4 february 29 leap");
    endtask

    task automatic t_year();
        roll(32'h0045_0C1F, 32'h0046_0101, "R5 year carry keeps leap");
        roll(32'h0006_0C1F, 32'h0007_0101, "R5 year carry leap clear");
    endtask

    task automatic t_time_zero();
        logic [31:0] v;
        wr(8'h04, 32'h0000_010F);
        wr(8'h08, 32'h0017_3B3B);
        ticks(TPS - 1);
        wr(8'h08, 32'h0);
        rd(8'h04, v); check(v, 32'h0000_010F, "R6 zero time write keeps date");
        ticks(TPS);
        rd(8'h04, v); check(v, 32'h0000_010F, "R6 date still held");
        rd(8'h08, v); check(v, 32'h0000_0001, "R6 time runs from zero");
        wr(8'h04, 32'h0052_0A07);
        rd(8'h04, v); check(v, 32'h0052_0A07, "R6 date write as whole");
    endtask

    task automatic t_key();
        logic [31:0] v;
        ticks(BUSY_T);
        wr(8'h00, 32'h0000_4009);
        rd(8'h00, v); check(v, 32'h0, "R7 unkeyed write ignored");
        check({31'b0, ext_osc_sel}, 32'h0, "R7 osc select kept");
        wr(8'h00, 32'h16AA_FFFF);
        rd(8'h00, v); check(v, 32'h0000_4089, "R7 keyed write plus busy");
        check({31'b0, ext_osc_sel}, 32'h1, "R7 external selected");
        ticks(BUSY_T);
        wr(8'h00, 32'h16AB_0000);
        rd(8'h00, v); check(v, 32'h0000_4009, "R7 wrong key no change no busy");
        wr(8'h00, 32'h16AA_0000);
        rd(8'h00, v); check(v & 32'h0000_4009, 32'h0, "R7 keyed clear");
    endtask

    task automatic t_busy();
        logic [31:0] v;
        ticks(BUSY_T);
        rd(8'h00, v); check(v & 32'h380, 32'h0, "R8 idle flags");
        wr(8'h04, 32'h0000_0101);
        rd(8'h00, v); check(v & 32'h380, 32'h100, "R8 date busy set");
        ticks(BUSY_T - 1);
        rd(8'h00, v); check(v & 32'h380, 32'h100, "R8 date busy held");
        ticks(1);
        rd(8'h00, v); check(v & 32'h380, 32'h0, "R8 date busy cleared");
        wr(8'h08, 32'h0);
        rd(8'h00, v); check(v & 32'h380, 32'h200, "R8 time busy set");
        ticks(BUSY_T);
        rd(8'h00, v); check(v & 32'h380, 32'h0, "R8 time busy cleared");
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); check(v, 32'h001F_3F3F, "R9 time unused bits zero");
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); check(v, 32'h007F_0F1F, "R9 date unused bits zero");
        rd(8'h0C, v); check(v, 32'h0, "R9 unmapped offset");
    endtask

    initial begin
        t_reset();
        t_seconds();
        t_hours();
        t_months();
        t_year();
        t_time_zero();
        t_key();
        t_busy();
        t_fields();
        wr(8'h00, 32'h16AA_0001);
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule